// File: doc/BRIEF.md
# Dual-Mode 8-Bit Capture Timer

This block is an 8-bit up-counter with two modes, picked by a mode input. As an interval timer, it counts on a prescaled enable and flags each wrap from 0xFF to 0x00. As a capture timer, it also watches an asynchronous capture pin through a two-flop synchronizer. On each rising edge of that pin it copies the running count into a rising-edge capture register. On each falling edge it copies the count into a falling-edge capture register. Edges can also be set to clear the counter.

One free-running 6-bit prescaler supplies the count enable, and a 2-bit field picks among four rates. Overflow is reported by two sticky flags. In capture mode, the flag that is set depends on the level of the synchronized pin at the moment of the wrap. One sticky request flag collects the selected edge and, when enabled, overflow events. The interrupt output is that flag gated by an enable bit.

Software reaches the block through a small register port. Writes are synchronous. Reads are combinational on a 3-bit address.

Top module: `cap_timer8`

## Requirements
- R1: While `rst_n` is low, every readable register (control at address 0, request at 1, count at 2, rising capture at 3, falling capture at 4) reads 0x00 and `irq` is low.
- R2: The count increases by one on each selected enable and wraps from 0xFF to 0x00.
- R3: Control bits [1:0] select the count rate: 00 is clock/64, 01 is clock/32, 10 is clock/8 and 11 is clock/2. Reset selects /64, so the count first reads 1 after the 64th clock edge following reset release. Any 64-cycle window holds exactly 64/divisor advances.
- R4: In capture mode (`mode_cap`=1), a pin level change is detected two clock edges after it is first sampled. At the third edge, the count held during the detection cycle is copied into address 3 for a rising edge, or into address 4 for a falling edge.
- R5: In interval mode (`mode_cap`=0), pin edges change neither capture register, never clear the count and never set the request flag.
- R6: Control bit 4 selects which edge sets the request flag (request register bit 0) in capture mode: 1 selects rising edges, 0 selects falling edges.
- R7: Control bits [3:2] choose which edges clear the counter in capture mode: 00 none, 01 rising, 10 falling, 11 both. The capture register keeps the value from before the clear, and the count becomes 0 at the next enable.
- R8: In capture mode, a wrap while the synchronized pin is high sets control bit 6 (high overflow). A wrap while the pin is low sets control bit 7 (low overflow).
- R9: In interval mode, every wrap sets control bit 7 whatever the pin level. In either mode, a wrap also sets the request flag when control bit 5 (overflow request enable) is 1.
- R10: `irq` equals the request flag ANDed with request register bit 1 (interrupt enable).
- R11: Control bits 6 and 7 and request bit 0 are sticky. Writing 0 clears them and writing 1 leaves them unchanged. A hardware set in the same cycle as a clearing write wins.
- R12: Writes to addresses 2, 3 and 4 are ignored. Addresses 5 to 7 read 0x00. Control bits [5:0] read back as written, and request bit 1 reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cap | input | 1 | 1 selects capture mode, 0 selects interval mode |
| cap_pin | input | 1 | Asynchronous capture input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data for `rd_addr` |
| irq | output | 1 | Interrupt request |

## Verification
Faults in the prescaler or rate decode show up in the first count read, no later than 64 cycles after a rate change. A synchronizer or edge-detect fault leaves a capture register off from the count seen one cycle earlier, and this is visible three cycles after the pin moves. A lost pending clear leaves a nonzero count four cycles after the edge. Flag-merge faults appear at the first overflow, at most 512 cycles away at /2. The bench times a clearing write to land on that overflow edge.

// File: rtl/cap_timer8.sv
module cap_timer8 #(
  parameter int DW = 8,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_cap,
  input  logic          cap_pin,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_REQ  = 3'd1;
  localparam logic [2:0] A_CNT  = 3'd2;
  localparam logic [2:0] A_CAPR = 3'd3;
  localparam logic [2:0] A_CAPF = 3'd4;
  localparam logic [DW-1:0] TOP = {DW{1'b1}};

  logic [PW-1:0] pre;
  logic [1:0]    clk_sel, clr_sel;
  logic          edge_sel, ovf_ie, ovf_hi, ovf_lo, req, irq_en;
  logic [DW-1:0] cnt, cap_rise, cap_fall;
  logic [2:0]    sh;
  logic          clr_pend, tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;

  always_comb
    case (clk_sel)
      2'd0:    tick = &pre;
      2'd1:    tick = &pre[PW-2:0];
      2'd2:    tick = &pre[2:0];
      default: tick = pre[0];
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], cap_pin};

  wire lvl      = sh[1];
  wire rise     = mode_cap & sh[1] & ~sh[2];
  wire fall     = mode_cap & ~sh[1] & sh[2];
  wire clr_hit  = (rise & clr_sel[0]) | (fall & clr_sel[1]);
  wire ovf      = tick & ~clr_pend & (cnt == TOP);
  wire set_hi   = ovf & mode_cap & lvl;
  wire set_lo   = ovf & ~(mode_cap & lvl);
  wire set_req  = (edge_sel ? rise : fall) | (ovf & ovf_ie);
  wire wr_ctrl  = wr_en && wr_addr == A_CTRL;
  wire wr_req   = wr_en && wr_addr == A_REQ;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt      <= '0;
      clr_pend <= 1'b0;
    end else begin
      clr_pend <= clr_hit | (clr_pend & ~tick);
      if (tick) cnt <= clr_pend ? '0 : cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_rise <= '0;
      cap_fall <= '0;
    end else begin
      if (rise) cap_rise <= cnt;
      if (fall) cap_fall <= cnt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_sel  <= 2'd0;
      clr_sel  <= 2'd0;
      edge_sel <= 1'b0;
      ovf_ie   <= 1'b0;
      irq_en   <= 1'b0;
    end else begin
      if (wr_ctrl) {ovf_ie, edge_sel, clr_sel, clk_sel} <= wr_data[5:0];
      if (wr_req)  irq_en <= wr_data[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf_hi <= 1'b0;
      ovf_lo <= 1'b0;
      req    <= 1'b0;
    end else begin
      ovf_hi <= set_hi  | (ovf_hi & ~(wr_ctrl & ~wr_data[6]));
      ovf_lo <= set_lo  | (ovf_lo & ~(wr_ctrl & ~wr_data[7]));
      req    <= set_req | (req & ~(wr_req & ~wr_data[0]));
    end

  always_comb
    case (rd_addr)
      A_CTRL:  rd_data = {ovf_lo, ovf_hi, ovf_ie, edge_sel, clr_sel, clk_sel};
      A_REQ:   rd_data = {{(DW-2){1'b0}}, irq_en, req};
      A_CNT:   rd_data = cnt;
      A_CAPR:  rd_data = cap_rise;
      A_CAPF:  rd_data = cap_fall;
      default: rd_data = '0;
    endcase

  assign irq = req & irq_en;
endmodule

module cap_timer8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_cap,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] cnt,
  input logic [7:0] cap_rise,
  input logic [7:0] cap_fall,
  input logic       clr_pend,
  input logic       ovf_hi,
  input logic       ovf_lo
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != $past(cnt) |-> (cnt == $past(cnt) + 8'd1) || (cnt == 8'd0));

  p_wrap_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 8'd0 && $past(cnt) == 8'hFF && !$past(clr_pend)) |-> (ovf_hi || ovf_lo));

  p_no_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_cap |=> ($stable(cap_rise) && $stable(cap_fall)));

  p_hi_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hi && !(wr_en && wr_addr == 3'd0 && !wr_data[6])) |=> ovf_hi);

  p_lo_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_lo && !(wr_en && wr_addr == 3'd0 && !wr_data[7])) |=> ovf_lo);
endmodule

bind cap_timer8 cap_timer8_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_cap(mode_cap), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .cnt(cnt), .cap_rise(cap_rise),
  .cap_fall(cap_fall), .clr_pend(clr_pend), .ovf_hi(ovf_hi), .ovf_lo(ovf_lo)
);

// File: tb/cap_timer8_tb_top.sv
module cap_timer8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_cap = 1'b0, cap_pin = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;
  int         n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  cap_timer8 dut_i (.clk(clk), .rst_n(rst_n), .mode_cap(mode_cap), .cap_pin(cap_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq));

  // {is_write, addr, data, expected read}
  localparam logic [19:0] VEC [14] = '{
    {1'b1, 3'd0, 8'h3F, 8'h00}, {1'b0, 3'd0, 8'h00, 8'h3F},
    {1'b1, 3'd0, 8'hC0, 8'h00}, {1'b0, 3'd0, 8'h00, 8'h00},
    {1'b1, 3'd1, 8'h03, 8'h00}, {1'b0, 3'd1, 8'h00, 8'h02},
    {1'b1, 3'd1, 8'h00, 8'h00}, {1'b0, 3'd1, 8'h00, 8'h00},
    {1'b1, 3'd3, 8'h55, 8'h00}, {1'b0, 3'd3, 8'h00, 8'h00},
    {1'b1, 3'd4, 8'hAA, 8'h00}, {1'b0, 3'd4, 8'h00, 8'h00},
    {1'b0, 3'd5, 8'h00, 8'h00}, {1'b0, 3'd7, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(input logic v, output logic [7:0] c2);
    @(negedge clk) cap_pin = v;
    @(negedge clk);
    @(negedge clk) rd(3'd2, c2);
    @(negedge clk);
  endtask

  task automatic wait_ff();
    logic [7:0] p, c;
    rd(3'd2, p);
    forever begin
      @(negedge clk) rd(3'd2, c);
      if (c == 8'hFF && p != 8'hFF) break;
      p = c;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    logic [7:0] v, c0, c1, c2, cr, cf;
    // R1 reset state
    #3;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reset reg", v, 8'h00);
    end
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    // R3 default /64
    repeat (63) @(negedge clk);
    rd(3'd2, v); chk("R3 /64 before 64th edge", v, 8'h00);
    @(negedge clk) rd(3'd2, v); chk("R3 /64 at 64th edge", v, 8'h01);

    // R12 R11 register map table
    for (int i = 0; i < 14; i++) begin
      if (VEC[i][19]) wr(VEC[i][18:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][18:16], v);
        chk("R12 R11 register table", v, VEC[i][7:0]);
      end
    end

    // R3 rate encodings over one 64-cycle window
    for (int s = 1; s < 4; s++) begin
      wr(3'd0, 8'(s));
      rd(3'd2, c0);
      repeat (64) @(negedge clk);
      rd(3'd2, c1);
      chk("R3 rate", c1 - c0, (s == 1) ? 8'd2 : (s == 2) ? 8'd8 : 8'd32);
    end

    // R12 count write ignored
    rd(3'd2, c0);
    wr(3'd2, c0 + 8'h80);
    rd(3'd2, c1);
    chk("R12 count write ignored", 8'(c1 - c0 < 8'd3), 8'h01);

    // R4 R6 capture, edge select rising, no clear
    mode_cap = 1'b1;
    wr(3'd0, 8'h13);
    wr(3'd1, 8'h00);
    probe(1'b1, c2);
    rd(3'd3, v); chk("R4 rising capture", v, c2);
    rd(3'd1, v); chk("R6 rising sets request", v, 8'h01);
    wr(3'd1, 8'h00);
    probe(1'b0, c2);
    rd(3'd4, v); chk("R4 falling capture", v, c2);
    rd(3'd1, v); chk("R6 falling ignored when rising selected", v, 8'h00);

    // R7 clear on rising only, edge select falling
    wr(3'd0, 8'h07);
    probe(1'b1, c2);
    rd(3'd3, v); chk("R7 capture keeps pre-clear count", v, c2);
    rd(3'd1, v); chk("R6 rising ignored when falling selected", v, 8'h00);
    repeat (2) @(negedge clk);
    rd(3'd2, v); chk("R7 rising clear", v, 8'h00);
    probe(1'b0, c2);
    repeat (2) @(negedge clk);
    rd(3'd2, v); chk("R7 falling does not clear", 8'(v != 8'h00), 8'h01);
    rd(3'd1, v); chk("R6 falling sets request", v, 8'h01);

    // R7 both edges
    wr(3'd0, 8'h0F);
    probe(1'b1, c2);
    repeat (2) @(negedge clk);
    rd(3'd2, v); chk("R7 both: rising clears", v, 8'h00);
    repeat (4) @(negedge clk);
    probe(1'b0, c2);
    repeat (2) @(negedge clk);
    rd(3'd2, v); chk("R7 both: falling clears", v, 8'h00);

    // R8 R9 R10 R11 overflow with pin high, clear write on the wrap edge
    wr(3'd0, 8'h23);
    cap_pin = 1'b1;
    repeat (4) @(negedge clk);
    wr(3'd1, 8'h02);
    wait_ff();
    rd(3'd0, v); chk("R8 no flag before wrap", v, 8'h23);
    chk("R10 irq low before wrap", {7'd0, irq}, 8'h00);
    wr(3'd0, 8'h23);
    rd(3'd0, v); chk("R8 R11 high flag wins over clear", v, 8'h63);
    rd(3'd2, v); chk("R2 wrap to zero", v, 8'h00);
    rd(3'd1, v); chk("R9 overflow sets request", v, 8'h03);
    chk("R10 irq raised", {7'd0, irq}, 8'h01);
    wr(3'd1, 8'h03);
    rd(3'd1, v); chk("R11 writing 1 keeps request", v, 8'h03);
    wr(3'd1, 8'h00);
    chk("R10 irq masked by enable", {7'd0, irq}, 8'h00);
    wr(3'd1, 8'h02);
    rd(3'd1, v); chk("R11 request cleared", v, 8'h02);
    wr(3'd0, 8'h03);
    rd(3'd0, v); chk("R11 flag cleared by write 0", v, 8'h03);

    // R5 interval mode ignores edges
    mode_cap = 1'b0;
    wr(3'd0, 8'h0F);
    rd(3'd3, cr); rd(3'd4, cf); rd(3'd2, c0);
    @(negedge clk) cap_pin = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk) cap_pin = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd2, c1); chk("R5 no clear in interval mode", c1 - c0, 8'd4);
    rd(3'd3, v); chk("R5 rising capture unchanged", v, cr);
    rd(3'd4, v); chk("R5 falling capture unchanged", v, cf);
    rd(3'd1, v); chk("R5 no request in interval mode", v, 8'h02);

    // R9 interval overflow with pin high
    wait_ff();
    repeat (2) @(negedge clk);
    rd(3'd0, v); chk("R9 interval wrap sets low flag", v, 8'h8F);
    rd(3'd1, v); chk("R9 no request without enable", v, 8'h02);
    wr(3'd0, 8'h2F);
    wait_ff();
    repeat (2) @(negedge clk);
    rd(3'd1, v); chk("R9 request with overflow enable", v, 8'h03);

    finish_run();
  end
endmodule